// File: doc/BRIEF.md
# End-to-End Path Delay Smoother

This block turns the four timestamps of one end-to-end delay exchange into a corrected, smoothed one-way path delay. The four timestamps are: SYNC leaving the time source, SYNC arriving locally, the local delay request leaving, and that request arriving at the time source. For each exchange it takes half the round trip and adds a signed, programmable correction for unequal receive and transmit paths. It then averages the result over a window of the most recent samples, so that one late or early exchange moves the result only a fraction of its error.

A servo loop uses the output. It subtracts the smoothed delay from the measured SYNC offset before it adjusts the local clock rate. Configuration is two values: a signed correction in nanoseconds and a two-bit window exponent. Both are written together through a single strobe. A window exponent of n averages the last 2^n samples. While the window is still filling after reset or after a change of size, the block averages only the samples it holds.

Top module: `mpd_averager`

## Requirements
- R1: After reset `delay_valid` is 0 and `delay_ns` is 0, the correction is +51 ns (0x33) and the window exponent is 3 (eight samples), both of which apply to the first sample.
- R2: Each leg is the difference of its two timestamps taken modulo 2^TS_W and read as a signed value, so a counter wrap between them is harmless. The raw delay is the sum of the SYNC leg (arrival minus departure) and the request leg (arrival minus departure), arithmetically shifted right by one, which rounds toward minus infinity.
- R3: The sample entering the window is the raw delay plus the signed correction; a positive correction stands for a slower receive path. A correction written in one cycle applies to samples presented in later cycles.
- R4: A sample presented in cycle k produces `delay_valid` high in cycle k+2 only, one cycle wide; back-to-back samples give back-to-back results.
- R5: With a full window of 2^n samples, `delay_ns` is the sum of the last 2^n samples shifted arithmetically right by n, and the oldest sample leaves as each new one enters.
- R6: While fewer than 2^n samples are held, `delay_ns` is the sum of the held samples divided by their count, rounded toward minus infinity.
- R7: A configuration write whose window exponent differs from the current one empties the window, and filling restarts from the next sample.
- R8: A configuration write that keeps the current window exponent leaves the held samples in place.
- R9: A sample presented in the same cycle as a configuration write is discarded and produces no result.
- R10: Between results, `delay_ns` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| sample_valid | input | 1 | One exchange's timestamps are present this cycle |
| ts_sync_tx | input | TS_W | SYNC departure time at the source, ns |
| ts_sync_rx | input | TS_W | SYNC arrival time here, ns |
| ts_req_tx | input | TS_W | Delay request departure time here, ns |
| ts_req_rx | input | TS_W | Delay request arrival time at the source, ns |
| cfg_we | input | 1 | Write strobe for the two configuration values |
| cfg_asym_ns | input | ASYM_W | Signed path correction, ns |
| cfg_avg_exp | input | EXP_W | Window exponent n (window of 2^n samples) |
| delay_valid | output | 1 | One-cycle strobe: new smoothed delay |
| delay_ns | output | DLY_W | Smoothed delay, signed ns |

## Verification
The bench narrows the timestamps to TS_W = 16 and keeps the other parameters at their defaults (MAX_EXP = 3, 32-bit correction and output). With 16-bit timestamps, counter wrap between two stamps and negative legs come from small literal values. Keeping MAX_EXP at 3 puts every window size from one to eight samples within reach, and an eight-deep fill and slide takes only a few transactions. The directed scenarios also cover odd round-trip sums, negative corrections, and a configuration write that lands on a sample cycle.

// File: rtl/mpd_pkg.sv
package mpd_pkg;

   // Reset value of the path correction, ns
   localparam int DEF_ASYM_NS = 51;
   // Reset value of the window exponent
   localparam int DEF_AVG_EXP = 3;

   // Width needed for a window count of 0 .. 2**max_exp
   function automatic int cnt_width(input int max_exp);
      return max_exp + 1;
   endfunction

endpackage

// File: rtl/mpd_sample_calc.sv
module mpd_sample_calc #(
   parameter int TS_W   = 48,
   parameter int ASYM_W = 32,
   parameter int DLY_W  = 32
) (
   input  logic [TS_W-1:0]          sync_tx,
   input  logic [TS_W-1:0]          sync_rx,
   input  logic [TS_W-1:0]          req_tx,
   input  logic [TS_W-1:0]          req_rx,
   input  logic signed [ASYM_W-1:0] asym,
   output logic signed [DLY_W-1:0]  sample
);

   localparam int LEG_W = TS_W + 1;
   localparam int XW    = ((LEG_W > ASYM_W) ? LEG_W : ASYM_W) + 2;

   logic [TS_W-1:0]        fwd_raw, rev_raw;
   logic signed [TS_W-1:0] fwd_leg, rev_leg;
   logic signed [XW-1:0]   leg_sum, half_rt, corrected;

   // Differences taken modulo 2**TS_W, then read as signed
   assign fwd_raw   = sync_rx - sync_tx;
   assign rev_raw   = req_rx - req_tx;
   assign fwd_leg   = $signed(fwd_raw);
   assign rev_leg   = $signed(rev_raw);
   assign leg_sum   = XW'(fwd_leg) + XW'(rev_leg);
   assign half_rt   = leg_sum >>> 1;
   assign corrected = half_rt + XW'(asym);

   generate
      if (XW >= DLY_W) begin : g_narrow
         logic unused_hi;
         assign sample    = corrected[DLY_W-1:0];
         assign unused_hi = ^corrected[XW-1:DLY_W-1];
      end else begin : g_widen
         assign sample = DLY_W'(corrected);
      end
   endgenerate

endmodule

// File: rtl/mpd_window.sv
module mpd_window #(
   parameter int DLY_W   = 32,
   parameter int MAX_EXP = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          flush,
   input  logic                          push,
   input  logic signed [DLY_W-1:0]       sample,
   input  logic [MAX_EXP:0]              depth,
   output logic signed [DLY_W+MAX_EXP:0] sum,
   output logic [MAX_EXP:0]              count
);

   localparam int MAX_DEPTH = 1 << MAX_EXP;
   localparam int PTR_W     = MAX_EXP;
   localparam int CNT_W     = MAX_EXP + 1;
   localparam int SUM_W     = DLY_W + MAX_EXP + 1;

   logic signed [DLY_W-1:0] slot [MAX_DEPTH];
   logic [PTR_W-1:0]        wr_ptr;
   logic [CNT_W-1:0]        ptr_inc;
   logic                    full;
   logic signed [SUM_W-1:0] leaving;

   assign full    = (count == depth);
   assign ptr_inc = CNT_W'(wr_ptr) + CNT_W'(1);
   assign leaving = full ? SUM_W'(slot[wr_ptr]) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < MAX_DEPTH; i++) slot[i] <= '0;
      end else if (push && !flush) begin
         slot[wr_ptr] <= sample;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         sum    <= '0;
         count  <= '0;
         wr_ptr <= '0;
      end else if (push) begin
         sum    <= sum + SUM_W'(sample) - leaving;
         count  <= full ? count : count + CNT_W'(1);
         wr_ptr <= (ptr_inc == depth) ? '0 : ptr_inc[PTR_W-1:0];
      end
   end

endmodule

// File: rtl/mpd_avg_div.sv
module mpd_avg_div #(
   parameter int DLY_W   = 32,
   parameter int MAX_EXP = 3
) (
   input  logic signed [DLY_W+MAX_EXP:0] sum,
   input  logic [MAX_EXP:0]              count,
   input  logic [MAX_EXP:0]              depth,
   input  logic [MAX_EXP:0]              exp_n,
   output logic signed [DLY_W-1:0]       avg
);

   localparam int SUM_W = DLY_W + MAX_EXP + 1;

   logic signed [SUM_W-1:0] den, quo_fill, rem_fill, quo;
   logic                    unused_hi;

   assign den = $signed(SUM_W'(count));

   always_comb begin
      quo_fill = '0;
      rem_fill = '0;
      if (count != '0) begin
         quo_fill = sum / den;
         rem_fill = sum % den;
         // truncation toward zero -> floor
         if (rem_fill != '0 && sum < 0) quo_fill = quo_fill - SUM_W'(1);
      end
   end

   // Full window: power-of-two divide is a plain arithmetic shift
   assign quo       = (count == depth) ? (sum >>> exp_n) : quo_fill;
   assign avg       = quo[DLY_W-1:0];
   assign unused_hi = ^quo[SUM_W-1:DLY_W];

endmodule

// File: rtl/mpd_averager.sv
module mpd_averager #(
   parameter int TS_W    = 48,
   parameter int ASYM_W  = 32,
   parameter int DLY_W   = 32,
   parameter int EXP_W   = 2,
   parameter int MAX_EXP = 3,
   parameter int DEF_ASYM = mpd_pkg::DEF_ASYM_NS,
   parameter int DEF_EXP  = mpd_pkg::DEF_AVG_EXP
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sample_valid,
   input  logic [TS_W-1:0]          ts_sync_tx,
   input  logic [TS_W-1:0]          ts_sync_rx,
   input  logic [TS_W-1:0]          ts_req_tx,
   input  logic [TS_W-1:0]          ts_req_rx,
   input  logic                     cfg_we,
   input  logic signed [ASYM_W-1:0] cfg_asym_ns,
   input  logic [EXP_W-1:0]         cfg_avg_exp,
   output logic                     delay_valid,
   output logic signed [DLY_W-1:0]  delay_ns
);

   localparam int CNT_W = mpd_pkg::cnt_width(MAX_EXP);
   localparam int SUM_W = DLY_W + MAX_EXP + 1;

   generate
      if (MAX_EXP < 1 || MAX_EXP > 8) begin : g_bad_exp
         $error("mpd_averager: MAX_EXP must be 1..8");
      end
      if (TS_W < 2 || DLY_W < 2 || ASYM_W < 2 || EXP_W < 1) begin : g_bad_w
         $error("mpd_averager: widths too small");
      end
      if (DEF_EXP > MAX_EXP || DEF_EXP < 0) begin : g_bad_def
         $error("mpd_averager: DEF_EXP out of range");
      end
   endgenerate

   logic signed [ASYM_W-1:0] asym_q;
   logic [EXP_W-1:0]         exp_q, exp_req;
   logic                     exp_change, push, push_q;
   logic [CNT_W-1:0]         exp_n, depth, win_count;
   logic signed [DLY_W-1:0]  sample, avg;
   logic signed [SUM_W-1:0]  win_sum;

   // Exponents above MAX_EXP saturate
   assign exp_req    = (cfg_avg_exp > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : cfg_avg_exp;
   assign exp_change = cfg_we && (exp_req != exp_q);
   assign push       = sample_valid && !cfg_we;
   assign exp_n      = CNT_W'(exp_q);
   assign depth      = CNT_W'(1) << exp_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         asym_q <= ASYM_W'(DEF_ASYM);
         exp_q  <= EXP_W'(DEF_EXP);
      end else if (cfg_we) begin
         asym_q <= cfg_asym_ns;
         exp_q  <= exp_req;
      end
   end

   mpd_sample_calc #(
      .TS_W   (TS_W),
      .ASYM_W (ASYM_W),
      .DLY_W  (DLY_W)
   ) u_calc (
      .sync_tx (ts_sync_tx),
      .sync_rx (ts_sync_rx),
      .req_tx  (ts_req_tx),
      .req_rx  (ts_req_rx),
      .asym    (asym_q),
      .sample  (sample)
   );

   mpd_window #(
      .DLY_W   (DLY_W),
      .MAX_EXP (MAX_EXP)
   ) u_win (
      .clk    (clk),
      .rst_n  (rst_n),
      .flush  (exp_change),
      .push   (push),
      .sample (sample),
      .depth  (depth),
      .sum    (win_sum),
      .count  (win_count)
   );

   mpd_avg_div #(
      .DLY_W   (DLY_W),
      .MAX_EXP (MAX_EXP)
   ) u_div (
      .sum   (win_sum),
      .count (win_count),
      .depth (depth),
      .exp_n (exp_n),
      .avg   (avg)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         push_q      <= 1'b0;
         delay_valid <= 1'b0;
         delay_ns    <= '0;
      end else begin
         push_q      <= push;
         delay_valid <= push_q;
         if (push_q) delay_ns <= avg;
      end
   end

endmodule

// File: rtl/mpd_averager_chk.sv
module mpd_averager_chk #(
   parameter int DLY_W   = 32,
   parameter int MAX_EXP = 3
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    sample_valid,
   input logic                    cfg_we,
   input logic                    push,
   input logic                    flush,
   input logic [MAX_EXP:0]        count,
   input logic [MAX_EXP:0]        depth,
   input logic                    delay_valid,
   input logic signed [DLY_W-1:0] delay_ns
);

   // R4
   valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      delay_valid |-> $past(sample_valid && !cfg_we, 2));

   // R5
   cnt_le_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= depth);

   // R6
   fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !flush && count < depth) |=> (count == $past(count) + (MAX_EXP+1)'(1)));

   // R7
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (count == '0));

   // R9
   collide_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_valid && cfg_we) |=> ##1 !delay_valid);

   // R10
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !delay_valid |-> $stable(delay_ns));

endmodule

bind mpd_averager mpd_averager_chk #(
   .DLY_W   (DLY_W),
   .MAX_EXP (MAX_EXP)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sample_valid (sample_valid),
   .cfg_we       (cfg_we),
   .push         (push),
   .flush        (exp_change),
   .count        (win_count),
   .depth        (depth),
   .delay_valid  (delay_valid),
   .delay_ns     (delay_ns)
);

// File: tb/mpd_averager_bench.sv
`timescale 1ns/1ps
module mpd_averager_bench;

   localparam int TS_W = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sample_valid = 1'b0;
   logic [15:0] ts_sync_tx = '0, ts_sync_rx = '0, ts_req_tx = '0, ts_req_rx = '0;
   logic        cfg_we = 1'b0;
   logic signed [31:0] cfg_asym_ns = '0;
   logic [1:0]  cfg_avg_exp = '0;
   logic        delay_valid;
   logic signed [31:0] delay_ns;

   int errors = 0, checks = 0;
   bit done = 0;

   // reference model state
   int hist [8];
   int mcnt = 0, mptr = 0, mexp = 3, masym = 51;

   always #2.5 clk = ~clk;

   mpd_averager #(.TS_W(TS_W)) u_mpd_averager (
      .clk, .rst_n, .sample_valid,
      .ts_sync_tx, .ts_sync_rx, .ts_req_tx, .ts_req_rx,
      .cfg_we, .cfg_asym_ns, .cfg_avg_exp,
      .delay_valid, .delay_ns
   );

   task automatic check(input string req, input int act, input int expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   function automatic int floordiv(input int a, input int b);
      int q;
      q = a / b;
      if ((a % b) != 0 && a < 0) q = q - 1;
      return q;
   endfunction

   function automatic int raw_delay(input logic [15:0] a, b, c, d);
      logic [15:0] f, r;
      int s;
      f = b - a;
      r = d - c;
      s = int'($signed(f)) + int'($signed(r));
      return s >>> 1;
   endfunction

   function automatic int model_push(input int s);
      int depth, tot;
      depth = 1 << mexp;
      hist[mptr] = s;
      if (mcnt < depth) mcnt++;
      mptr = (mptr + 1) % depth;
      tot = 0;
      for (int i = 0; i < mcnt; i++) tot += hist[i];
      return floordiv(tot, mcnt);
   endfunction

   task automatic model_cfg(input int asym, input int e);
      if (e != mexp) begin
         mcnt = 0;
         mptr = 0;
      end
      mexp  = e;
      masym = asym;
   endtask

   task automatic drive_ts(input logic [15:0] a, b, c, d);
      ts_sync_tx = a; ts_sync_rx = b; ts_req_tx = c; ts_req_rx = d;
   endtask

   task automatic send(input logic [15:0] a, b, c, d, input string req);
      int e;
      @(negedge clk);
      drive_ts(a, b, c, d);
      sample_valid = 1'b1;
      e = model_push(raw_delay(a, b, c, d) + masym);
      @(negedge clk);
      sample_valid = 1'b0;
      check("R4 no early valid", int'(delay_valid), 0);
      @(negedge clk);
      check("R4 valid at k+2", int'(delay_valid), 1);
      check(req, int'(delay_ns), e);
      @(negedge clk);
      check("R4 one-cycle pulse", int'(delay_valid), 0);
   endtask

   task automatic cfg_write(input int asym, input int e);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_asym_ns = asym;
      cfg_avg_exp = e[1:0];
      model_cfg(asym, e);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 reset valid", int'(delay_valid), 0);
      check("R1 reset delay", int'(delay_ns), 0);
      rst_n = 1'b1;
   endtask

   task automatic t_defaults_fill();
      // correction 51, window 8 from reset
      send(16'd100, 16'd1100, 16'd2000, 16'd3000, "R1 R3 default correction");
      send(16'd0, 16'd1200, 16'd0, 16'd1000, "R6 fill 2");
      send(16'd0, 16'd900, 16'd0, 16'd901, "R6 fill 3");
      send(16'd10, 16'd1010, 16'd20, 16'd1021, "R6 fill 4");
   endtask

   task automatic t_slide();
      cfg_write(0, 2);   // R7 size change flushes
      send(16'd0, 16'd500, 16'd0, 16'd500, "R7 first after flush");
      send(16'd0, 16'd600, 16'd0, 16'd600, "R6 fill");
      send(16'd0, 16'd700, 16'd0, 16'd700, "R6 fill 3 of 4");
      send(16'd0, 16'd800, 16'd0, 16'd800, "R5 full 4");
      send(16'd0, 16'd5000, 16'd0, 16'd5000, "R5 outlier enters");
      send(16'd0, 16'd900, 16'd0, 16'd900, "R5 oldest leaves");
   endtask

   task automatic t_back_to_back();
      int e1, e2;
      @(negedge clk);
      drive_ts(16'd0, 16'd300, 16'd0, 16'd300);
      sample_valid = 1'b1;
      e1 = model_push(raw_delay(16'd0, 16'd300, 16'd0, 16'd300) + masym);
      @(negedge clk);
      drive_ts(16'd0, 16'd100, 16'd0, 16'd101);
      e2 = model_push(raw_delay(16'd0, 16'd100, 16'd0, 16'd101) + masym);
      @(negedge clk);
      sample_valid = 1'b0;
      check("R4 back-to-back first valid", int'(delay_valid), 1);
      check("R5 back-to-back first", int'(delay_ns), e1);
      @(negedge clk);
      check("R4 back-to-back second valid", int'(delay_valid), 1);
      check("R5 back-to-back second", int'(delay_ns), e2);
      @(negedge clk);
      check("R4 pulse ends", int'(delay_valid), 0);
   endtask

   task automatic t_wrap_round();
      cfg_write(0, 0);   // single-sample window, output equals sample
      send(16'hFFF0, 16'h0010, 16'hFF00, 16'h0040, "R2 timestamp wrap");
      send(16'd0, 16'd3, 16'd0, 16'd4, "R2 odd sum floors");
      send(16'd100, 16'd90, 16'd200, 16'd195, "R2 negative floors");
   endtask

   task automatic t_correction();
      cfg_write(-40, 0);
      send(16'd0, 16'd100, 16'd0, 16'd100, "R3 negative correction");
      cfg_write(25, 0);
      send(16'd0, 16'd100, 16'd0, 16'd100, "R3 positive correction");
      send(16'd0, 16'd10, 16'd0, 16'd10, "R3 small delay with correction");
   endtask

   task automatic t_same_exp();
      cfg_write(0, 1);
      send(16'd0, 16'd400, 16'd0, 16'd400, "R7 window 2 start");
      cfg_write(7, 1);   // R8 same exponent keeps the held sample
      send(16'd0, 16'd200, 16'd0, 16'd201, "R8 no flush on same exponent");
   endtask

   task automatic t_collision();
      int held;
      held = int'(delay_ns);
      @(negedge clk);
      drive_ts(16'd0, 16'd9000, 16'd0, 16'd9000);
      sample_valid = 1'b1;
      cfg_we = 1'b1;
      cfg_asym_ns = 0;
      cfg_avg_exp = 2'd2;
      model_cfg(0, 2);
      @(negedge clk);
      sample_valid = 1'b0;
      cfg_we = 1'b0;
      check("R9 no valid k+1", int'(delay_valid), 0);
      @(negedge clk);
      check("R9 dropped sample", int'(delay_valid), 0);
      check("R10 hold after drop", int'(delay_ns), held);
      repeat (4) @(negedge clk);
      check("R10 hold idle", int'(delay_ns), held);
      send(16'd0, 16'd250, 16'd0, 16'd250, "R9 R7 next sample starts window");
   endtask

   initial begin
      t_reset();
      t_defaults_fill();
      t_slide();
      t_back_to_back();
      t_wrap_round();
      t_correction();
      t_same_exp();
      t_collision();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule